// File: doc/BRIEF.md
# Line DCC Double-Buffered Insertion Store

This block keeps a processor-loaded copy of the line data-communication-channel overhead (the nine bytes D4 through D12 of each outgoing frame) for a run of 24 frames, and substitutes those bytes into the transmit byte stream. The storage is split into two halves. One half feeds insertion while the processor fills the other. Writing the last data address of the block marks the freshly filled half as ready. At the following frame start, insertion moves to that half and begins again at its first frame.

The frame stream arrives one byte per cycle with a valid flag, a start-of-frame flag, a DCC flag and a DCC byte index. When the source-select input is low, every byte, DCC bytes included, passes through unchanged. When it is high, each DCC byte is replaced by the stored byte for the current frame and index. A sticky ready flag reports that the D12 byte of the final frame in the run has been inserted. An enable input gates this flag onto a registered interrupt line. Writing 1 to the flag's address clears it.

Top module: `dcc_pingpong_ins`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid, out_data, dcc_rdy and dcc_irq are all 0.
- R2: A byte with in_dcc low leaves on out_data two cycles after it enters, with out_valid high in that cycle and its value unchanged.
- R3: With src_sel low, DCC bytes pass through unchanged with the same two-cycle latency, and dcc_rdy is never set.
- R4: With src_sel high, a DCC byte with index k (0 to 8, meaning D4 to D12) in run frame f (0 to 23) leaves as the byte stored at data address f*9+k in the active half.
- R5: Processor writes to data addresses 0 to 215 go to the half not being inserted and do not change the bytes being inserted.
- R6: A write to address 215 commits the filled half. At the next start of frame, insertion switches to that half and restarts at frame 0.
- R7: With no commit pending, the frame after frame 23 is frame 0 of the same half.
- R8: dcc_rdy rises in the cycle after the index-8 DCC byte of frame 23 is inserted. It then stays high until it is cleared.
- R9: A write to address 216 with data bit 0 set clears dcc_rdy. A write there with bit 0 clear has no effect.
- R10: dcc_irq equals (dcc_rdy AND irq_en) delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Processor write strobe |
| cpu_addr | input | 8 | Write address: 0-215 data, 216 status |
| cpu_wdata | input | 8 | Write data |
| src_sel | input | 1 | 1 = insert stored bytes, 0 = pass through |
| irq_en | input | 1 | Interrupt enable for the ready flag |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Byte is the first of a frame |
| in_dcc | input | 1 | Byte is a line DCC byte |
| in_idx | input | 4 | DCC byte index 0-8 (D4-D12) |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| dcc_rdy | output | 1 | Sticky ready flag |
| dcc_irq | output | 1 | Registered, enabled ready interrupt |

## Verification
The checks assume several things about the inputs. A start-of-frame byte never carries the DCC flag. The DCC index stays within 0 to 8. Each frame offers each index once, in rising order. No processor write to the status address lands in the same cycle as a DCC byte that would set the flag. The stimulus follows these rules by construction. Each frame is a start byte, then the nine DCC bytes in order, then two plain bytes. Processor writes are issued only in idle gaps between frames. The commit write is always given well ahead of the next frame start, so no write falls between the commit and the swap.

// File: rtl/dcc_ins_pkg.sv
package dcc_ins_pkg;
  localparam int DCC_FRAMES = 24;
  localparam int DCC_BYTES  = 9;
  localparam int DCC_DW     = 8;

  typedef struct packed {
    logic              valid;
    logic              ins;
    logic [DCC_DW-1:0] data;
  } dcc_stage_t;
endpackage

// File: rtl/dcc_bank_ram.sv
module dcc_bank_ram #(
  parameter int DW = 8,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int ENTRIES = 2 ** AW;

  logic [DW-1:0] mem [ENTRIES];

  // simple dual-port, registered read: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcc_ins_ctrl.sv
module dcc_ins_ctrl #(
  parameter int FRAMES = 24,
  parameter int BYTES  = 9,
  parameter int CA_W   = 8,
  parameter int OFS_W  = 8,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_we,
  input  logic [CA_W-1:0]  cpu_addr,
  input  logic             clr_bit,
  input  logic             sof,
  input  logic             dcc_hit,
  input  logic             ins_en,
  input  logic [IDX_W-1:0] idx,
  input  logic             irq_en,
  output logic             act_bank,
  output logic [OFS_W-1:0] rd_ofs,
  output logic             rdy,
  output logic             irq
);
  localparam int FR_W      = $clog2(FRAMES);
  localparam int LAST_ADDR = FRAMES * BYTES - 1;
  localparam int STS_ADDR  = FRAMES * BYTES;

  logic [FR_W-1:0] frame_q;
  logic            pend_q;

  logic commit, clr, last_frame, set_rdy;
  assign commit     = cpu_we && (cpu_addr == CA_W'(LAST_ADDR));
  assign clr        = cpu_we && (cpu_addr == CA_W'(STS_ADDR)) && clr_bit;
  assign last_frame = (frame_q == FR_W'(FRAMES - 1));
  assign set_rdy    = dcc_hit && ins_en && (idx == IDX_W'(BYTES - 1)) && last_frame;

  assign rd_ofs = OFS_W'(int'(frame_q) * BYTES + int'(idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_bank <= 1'b0;
      frame_q  <= FR_W'(FRAMES - 1);
      pend_q   <= 1'b0;
    end else if (sof && pend_q) begin
      act_bank <= ~act_bank;
      frame_q  <= '0;
      pend_q   <= commit;
    end else begin
      if (sof)    frame_q <= last_frame ? '0 : frame_q + 1'b1;
      if (commit) pend_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy <= 1'b0;
      irq <= 1'b0;
    end else begin
      if (set_rdy)  rdy <= 1'b1;
      else if (clr) rdy <= 1'b0;
      irq <= rdy && irq_en;
    end
  end
endmodule

// File: rtl/dcc_pingpong_ins.sv
module dcc_pingpong_ins
  import dcc_ins_pkg::*;
#(
  parameter  int FRAMES = DCC_FRAMES,
  parameter  int BYTES  = DCC_BYTES,
  localparam int DEPTH  = FRAMES * BYTES,
  localparam int CA_W   = $clog2(DEPTH + 1),
  localparam int OFS_W  = $clog2(DEPTH),
  localparam int IDX_W  = $clog2(BYTES),
  localparam int MEM_AW = OFS_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_we,
  input  logic [CA_W-1:0]   cpu_addr,
  input  logic [DCC_DW-1:0] cpu_wdata,
  input  logic              src_sel,
  input  logic              irq_en,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_dcc,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [DCC_DW-1:0] in_data,
  output logic              out_valid,
  output logic [DCC_DW-1:0] out_data,
  output logic              dcc_rdy,
  output logic              dcc_irq
);
  logic              act_bank;
  logic [OFS_W-1:0]  rd_ofs;
  logic [DCC_DW-1:0] rd_data;
  logic              dcc_hit;
  logic              wr_data_en;
  dcc_stage_t        s1_q;

  assign dcc_hit    = in_valid && in_dcc;
  assign wr_data_en = cpu_we && (cpu_addr < CA_W'(DEPTH));

  dcc_ins_ctrl #(
    .FRAMES(FRAMES), .BYTES(BYTES), .CA_W(CA_W), .OFS_W(OFS_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cpu_we   (cpu_we),
    .cpu_addr (cpu_addr),
    .clr_bit  (cpu_wdata[0]),
    .sof      (in_valid && in_sof),
    .dcc_hit  (dcc_hit),
    .ins_en   (src_sel),
    .idx      (in_idx),
    .irq_en   (irq_en),
    .act_bank (act_bank),
    .rd_ofs   (rd_ofs),
    .rdy      (dcc_rdy),
    .irq      (dcc_irq)
  );

  // processor fills the idle half, insertion reads the active half
  dcc_bank_ram #(.DW(DCC_DW), .AW(MEM_AW)) u_ram (
    .clk   (clk),
    .we    (wr_data_en),
    .waddr ({~act_bank, cpu_addr[OFS_W-1:0]}),
    .wdata (cpu_wdata),
    .re    (dcc_hit),
    .raddr ({act_bank, rd_ofs}),
    .rdata (rd_data)
  );

  // stage 1 runs alongside the RAM read, stage 2 is the output register
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      s1_q.valid <= in_valid;
      s1_q.ins   <= dcc_hit && src_sel;
      s1_q.data  <= in_data;
      out_valid  <= s1_q.valid;
      out_data   <= s1_q.ins ? rd_data : s1_q.data;
    end
  end
endmodule

// File: rtl/dcc_pingpong_ins_chk.sv
module dcc_pingpong_ins_chk #(
  parameter  int FRAMES = 24,
  parameter  int BYTES  = 9,
  localparam int DEPTH  = FRAMES * BYTES,
  localparam int CA_W   = $clog2(DEPTH + 1),
  localparam int IDX_W  = $clog2(BYTES)
) (
  input logic             clk,
  input logic             rst,
  input logic             cpu_we,
  input logic [CA_W-1:0]  cpu_addr,
  input logic             clr_bit,
  input logic             src_sel,
  input logic             irq_en,
  input logic             in_valid,
  input logic             in_dcc,
  input logic [IDX_W-1:0] in_idx,
  input logic [7:0]       in_data,
  input logic             out_valid,
  input logic [7:0]       out_data,
  input logic             dcc_rdy,
  input logic             dcc_irq
);
  logic rst_q;
  logic clr_wr;
  assign clr_wr = cpu_we && (cpu_addr == CA_W'(DEPTH)) && clr_bit;

  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_q) begin
      AST_RESET_QUIET: assert (!out_valid && out_data == '0 && !dcc_rdy && !dcc_irq)
        else $error("outputs not quiet after reset"); // R1
    end
  end

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid) else $error("valid lost"); // R2

  AST_BYPASS_DATA: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(in_dcc && src_sel)) |-> ##2 (out_data == $past(in_data, 2)))
    else $error("bypass data altered"); // R3

  AST_RDY_ONLY_D12: assert property (@(posedge clk) disable iff (rst)
    $rose(dcc_rdy) |-> $past(in_valid && in_dcc && src_sel && in_idx == IDX_W'(BYTES - 1)))
    else $error("ready rose without last-index insertion"); // R8

  AST_RDY_STICKY: assert property (@(posedge clk) disable iff (rst)
    (dcc_rdy && !clr_wr) |=> dcc_rdy) else $error("ready dropped"); // R8

  AST_RDY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !(in_valid && in_dcc)) |=> !dcc_rdy) else $error("clear ignored"); // R9

  AST_IRQ_ON: assert property (@(posedge clk) disable iff (rst)
    (dcc_rdy && irq_en) |=> dcc_irq) else $error("irq missing"); // R10

  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (rst)
    !(dcc_rdy && irq_en) |=> !dcc_irq) else $error("irq spurious"); // R10
endmodule

bind dcc_pingpong_ins dcc_pingpong_ins_chk #(.FRAMES(FRAMES), .BYTES(BYTES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_we    (cpu_we),
  .cpu_addr  (cpu_addr),
  .clr_bit   (cpu_wdata[0]),
  .src_sel   (src_sel),
  .irq_en    (irq_en),
  .in_valid  (in_valid),
  .in_dcc    (in_dcc),
  .in_idx    (in_idx),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .dcc_rdy   (dcc_rdy),
  .dcc_irq   (dcc_irq)
);

// File: tb/tb_dcc_pingpong_ins.sv
`timescale 1ns/1ps
module tb_dcc_pingpong_ins;
  localparam int FRAMES = 24;
  localparam int BYTES  = 9;
  localparam int DEPTH  = FRAMES * BYTES;

  logic       clk = 1'b0;
  logic       rst;
  logic       cpu_we;
  logic [7:0] cpu_addr;
  logic [7:0] cpu_wdata;
  logic       src_sel, irq_en;
  logic       in_valid, in_sof, in_dcc;
  logic [3:0] in_idx;
  logic [7:0] in_data;
  logic       out_valid;
  logic [7:0] out_data;
  logic       dcc_rdy, dcc_irq;

  always #2.5 clk = ~clk;

  dcc_pingpong_ins dut (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .src_sel(src_sel), .irq_en(irq_en), .in_valid(in_valid), .in_sof(in_sof),
    .in_dcc(in_dcc), .in_idx(in_idx), .in_data(in_data), .out_valid(out_valid),
    .out_data(out_data), .dcc_rdy(dcc_rdy), .dcc_irq(dcc_irq)
  );

  int checks = 0;
  int fails  = 0;

  // scoreboard and reference state
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] shadow [2][DEPTH];
  bit         m_act  = 1'b0;
  bit         m_pend = 1'b0;
  int         m_cnt  = FRAMES - 1;
  int         seed   = 0;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive_byte(input bit sof, input bit dcc, input int idx,
                            input logic [7:0] d, input logic [7:0] e, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_sof = sof; in_dcc = dcc; in_idx = 4'(idx); in_data = d;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_dcc = 1'b0; in_idx = '0;
  endtask

  task automatic send_frame(input bit src, input string tag);
    logic [7:0] d;
    src_sel = src;
    if (m_pend) begin m_act = !m_act; m_cnt = 0; m_pend = 1'b0; end
    else m_cnt = (m_cnt == FRAMES - 1) ? 0 : m_cnt + 1;
    seed++;
    d = 8'(seed * 13);
    drive_byte(1'b1, 1'b0, 0, d, d, "R2");
    for (int k = 0; k < BYTES; k++) begin
      d = 8'(seed * 29 + k * 71 + 5);
      drive_byte(1'b0, 1'b1, k, d, src ? shadow[m_act][m_cnt * BYTES + k] : d, tag);
    end
    for (int k = 0; k < 2; k++) begin
      d = 8'(seed * 3 + k + 200);
      drive_byte(1'b0, 1'b0, 0, d, d, "R2");
    end
    idle();
  endtask

  task automatic cpu_write(input int addr, input logic [7:0] data);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = 8'(addr); cpu_wdata = data;
    if (addr < DEPTH) shadow[!m_act][addr] = data;
    if (addr == DEPTH - 1) m_pend = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  function automatic logic [7:0] pat_a(input int i);
    return 8'(i * 7 + 3);
  endfunction
  function automatic logic [7:0] pat_b(input int i);
    return 8'(i * 11) ^ 8'hA5;
  endfunction

  // monitor: pops one expected byte per output byte
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2: actual unexpected byte %0h expected none", out_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_data, e, t);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0; src_sel = 0; irq_en = 0;
    in_valid = 0; in_sof = 0; in_dcc = 0; in_idx = 0; in_data = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({7'd0, out_valid}, 8'd0, "R1");
    chk(out_data, 8'd0, "R1");
    chk({6'd0, dcc_rdy, dcc_irq}, 8'd0, "R1");

    // fill the idle half with pattern A and commit
    for (int i = 0; i < DEPTH; i++) cpu_write(i, pat_a(i));

    // full run with pass-through: no ready flag
    for (int f = 0; f < FRAMES; f++) send_frame(1'b0, "R3");
    chk({7'd0, dcc_rdy}, 8'd0, "R3");

    // insertion run of A; mid-run, fill the other half with B minus the commit address
    for (int f = 0; f < FRAMES; f++) begin
      send_frame(1'b1, (f < 6) ? "R4" : "R5");
      if (f == 5) for (int i = 0; i < DEPTH - 1; i++) cpu_write(i, pat_b(i));
      if (f == 12) chk({7'd0, dcc_rdy}, 8'd0, "R8");
    end
    chk({7'd0, dcc_rdy}, 8'd1, "R8");
    chk({7'd0, dcc_irq}, 8'd0, "R10");

    // status write with bit 0 clear leaves the flag alone
    cpu_write(DEPTH, 8'hFE);
    chk({7'd0, dcc_rdy}, 8'd1, "R9");

    @(negedge clk); irq_en = 1'b1;
    @(negedge clk);
    chk({7'd0, dcc_irq}, 8'd1, "R10");

    cpu_write(DEPTH, 8'h01);
    chk({7'd0, dcc_rdy}, 8'd0, "R9");
    @(negedge clk);
    chk({7'd0, dcc_irq}, 8'd0, "R10");

    // wrap within the same half
    for (int f = 0; f < 3; f++) send_frame(1'b1, "R7");

    // commit B mid-run: next frame restarts at frame 0 of B
    cpu_write(DEPTH - 1, pat_b(DEPTH - 1));
    for (int f = 0; f < FRAMES; f++) begin
      send_frame(1'b1, "R6");
      if (f == 20) chk({7'd0, dcc_rdy}, 8'd0, "R8");
    end
    chk({7'd0, dcc_rdy}, 8'd1, "R8");
    @(negedge clk);
    chk({7'd0, dcc_irq}, 8'd1, "R10");

    repeat (4) @(negedge clk);
    chk(8'(exp_q.size()), 8'd0, "R2");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule